// File: doc/BRIEF.md
# Four-Channel Log Attenuator, Digital Mixer and PWM Output Stage

This block is the back end of a simple square-wave and noise sound source. It receives four one-bit channel waveforms: three tone channels and one noise channel. It also receives a four-bit attenuation code for each channel. Each channel is turned into an amplitude through a logarithmic table with 2 dB between steps. A code of zero is the loudest setting. Larger codes are quieter, and the highest code mutes the channel.

The four amplitudes are added into an 8-bit mixed word that an external DAC can take directly. The waveforms are plain 0/1 signals with no DC offset, so a channel whose waveform is low adds nothing to the mix. A shared free-running counter drives two kinds of pulse-width-modulated outputs:

- one output for the mixed word, which needs only an RC filter;
- one output for each channel, for mixing outside the block.

The per-channel PWM level is the channel amplitude widened to the counter's width.

Top module: `psg_mix_pwm`

## Requirements
- R1: An attenuation code k (0..15) on a channel whose waveform is 1 gives that channel the amplitude at index k of this list: 63, 50, 40, 32, 25, 20, 16, 13, 10, 8, 6, 5, 4, 3, 2, 0.
- R2: Attenuation code 15 makes a channel contribute nothing, to the mixed word and to its own PWM output, whatever its waveform.
- R3: A channel whose waveform is 0 contributes zero amplitude, whatever its attenuation code.
- R4: `mix_word` equals the sum of the four channel amplitudes. The largest possible value is 252, so the sum never wraps.
- R5: `mix_word` is registered. It shows the sum for the inputs present at a rising clock edge right after that edge, and it does not change before that edge.
- R6: A free-running 8-bit counter starts at 0 after reset. While the inputs are steady, `mix_pwm` is high in exactly `mix_word` out of every 256 consecutive cycles.
- R7: While the inputs are steady, `ch_pwm[i]` is high in exactly L out of every 256 consecutive cycles. L = {a, a[5:4]}, where a is the 6-bit amplitude of channel i, so amplitude 63 gives 255.
- R8: A synchronous active-high reset clears `mix_word`, `mix_pwm` and `ch_pwm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_wave | input | 4 | Waveform bit of each channel; bit 3 is the noise channel |
| ch_att | input | 16 | Attenuation codes, channel i in bits [4i+3:4i] |
| mix_word | output | 8 | Registered sum of the four channel amplitudes |
| ch_pwm | output | 4 | PWM output of each channel |
| mix_pwm | output | 1 | PWM output of the mixed word |

## Verification
Suppose one table entry or one summing lane is wrong. That shows on `mix_word` one cycle after the affected code is applied, so the bench sweeps every code on every channel alone and compares each result with the listed amplitude. Bad scaling, a bad comparison or a bad counter shows only in PWM duty. The bench therefore counts high cycles over whole 256-cycle periods, which exposes any miscount of one cycle within a single period. The bench also checks `mix_word` both before and after the edge, which catches a latency off by one cycle.

// File: rtl/mixpwm_pkg.sv
`timescale 1ns/1ps
package mixpwm_pkg;

   localparam int unsigned TBL_ATT_W = 4;
   localparam int unsigned TBL_AMP_W = 6;

   // Log amplitude, 2 dB per step; the top code is silence.
   function automatic logic [TBL_AMP_W-1:0] att_to_amp(input logic [TBL_ATT_W-1:0] code);
      logic [TBL_AMP_W-1:0] a;
      case (code)
         4'd0:  a = 6'd63;
         4'd1:  a = 6'd50;
         4'd2:  a = 6'd40;
         4'd3:  a = 6'd32;
         4'd4:  a = 6'd25;
         4'd5:  a = 6'd20;
         4'd6:  a = 6'd16;
         4'd7:  a = 6'd13;
         4'd8:  a = 6'd10;
         4'd9:  a = 6'd8;
         4'd10: a = 6'd6;
         4'd11: a = 6'd5;
         4'd12: a = 6'd4;
         4'd13: a = 6'd3;
         4'd14: a = 6'd2;
         default: a = 6'd0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/mixpwm_atten.sv
`timescale 1ns/1ps
module mixpwm_atten
   import mixpwm_pkg::*;
#(
   parameter int unsigned ATT_W = 4,
   parameter int unsigned AMP_W = 6
) (
   input  logic             wave,
   input  logic [ATT_W-1:0] code,
   output logic [AMP_W-1:0] amp
);

   generate
      if (ATT_W != TBL_ATT_W || AMP_W != TBL_AMP_W) begin : g_bad_width
         $error("mixpwm_atten: widths must match the amplitude table");
      end
   endgenerate

   always_comb begin
      if (wave) amp = att_to_amp(code);
      else      amp = '0;
   end

endmodule

// File: rtl/mixpwm_sum.sv
`timescale 1ns/1ps
module mixpwm_sum #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned AMP_W  = 6,
   parameter int unsigned OUT_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_CH*AMP_W-1:0] amps,
   output logic [OUT_W-1:0]        sum_q
);

   localparam int unsigned SUM_MAX = NUM_CH * ((1 << AMP_W) - 1);

   generate
      if (SUM_MAX >= (1 << OUT_W)) begin : g_bad_sum
         $error("mixpwm_sum: OUT_W too narrow for the channel sum");
      end
   endgenerate

   logic [OUT_W-1:0] acc;

   always_comb begin
      acc = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         acc = acc + OUT_W'(amps[i*AMP_W +: AMP_W]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) sum_q <= '0;
      else     sum_q <= acc;
   end

endmodule

// File: rtl/mixpwm_pwm.sv
`timescale 1ns/1ps
module mixpwm_pwm #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] level,
   input  logic [W-1:0] cnt,
   output logic         pwm_q
);

   always_ff @(posedge clk) begin
      if (rst) pwm_q <= 1'b0;
      else     pwm_q <= (cnt < level);
   end

endmodule

// File: rtl/psg_mix_pwm.sv
`timescale 1ns/1ps
module psg_mix_pwm #(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned ATT_W      = 4,
   parameter int unsigned AMP_W      = 6,
   parameter int unsigned OUT_W      = 8,
   parameter int unsigned CNT_W      = 8,
   parameter bit          SCALE_REPL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_CH-1:0]       ch_wave,
   input  logic [NUM_CH*ATT_W-1:0] ch_att,
   output logic [OUT_W-1:0]        mix_word,
   output logic [NUM_CH-1:0]       ch_pwm,
   output logic                    mix_pwm
);

   localparam int unsigned PAD_W = CNT_W - AMP_W;

   generate
      if (OUT_W != CNT_W) begin : g_bad_cnt
         $error("psg_mix_pwm: mixed word and PWM counter must be equally wide");
      end
      if (CNT_W <= AMP_W || PAD_W > AMP_W) begin : g_bad_pad
         $error("psg_mix_pwm: counter width out of range for amplitude scaling");
      end
   endgenerate

   logic [CNT_W-1:0]        cnt_q;
   logic [NUM_CH*AMP_W-1:0] amps;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [AMP_W-1:0] amp;
      logic [CNT_W-1:0] lvl;
      logic [CNT_W-1:0] lvl_q;

      mixpwm_atten #(.ATT_W(ATT_W), .AMP_W(AMP_W)) u_att (
         .wave (ch_wave[i]),
         .code (ch_att[i*ATT_W +: ATT_W]),
         .amp  (amp)
      );

      assign amps[i*AMP_W +: AMP_W] = amp;

      if (SCALE_REPL) begin : g_repl
         assign lvl = {amp, amp[AMP_W-1 -: PAD_W]};
      end else begin : g_zero
         assign lvl = {amp, {PAD_W{1'b0}}};
      end

      always_ff @(posedge clk) begin
         if (rst) lvl_q <= '0;
         else     lvl_q <= lvl;
      end

      mixpwm_pwm #(.W(CNT_W)) u_pwm (
         .clk   (clk),
         .rst   (rst),
         .level (lvl_q),
         .cnt   (cnt_q),
         .pwm_q (ch_pwm[i])
      );
   end

   mixpwm_sum #(.NUM_CH(NUM_CH), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_sum (
      .clk   (clk),
      .rst   (rst),
      .amps  (amps),
      .sum_q (mix_word)
   );

   mixpwm_pwm #(.W(CNT_W)) u_mix_pwm (
      .clk   (clk),
      .rst   (rst),
      .level (mix_word),
      .cnt   (cnt_q),
      .pwm_q (mix_pwm)
   );

endmodule

// File: rtl/psg_mix_pwm_chk.sv
`timescale 1ns/1ps
module psg_mix_pwm_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ATT_W  = 4,
   parameter int unsigned AMP_W  = 6,
   parameter int unsigned OUT_W  = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic [NUM_CH-1:0]       ch_wave,
   input logic [NUM_CH*ATT_W-1:0] ch_att,
   input logic [OUT_W-1:0]        mix_word,
   input logic [NUM_CH-1:0]       ch_pwm,
   input logic                    mix_pwm
);

   localparam logic [OUT_W-1:0] AMP_TOP = OUT_W'((1 << AMP_W) - 1);

   AST_LONE_LOUD: assert property (@(posedge clk) disable iff (rst)
      (ch_wave == NUM_CH'(1) && ch_att[ATT_W-1:0] == '0) |=> (mix_word == AMP_TOP)); // R1

   AST_ALL_MUTED: assert property (@(posedge clk) disable iff (rst)
      (ch_att == '1) |=> (mix_word == '0)); // R2

   AST_CH0_MUTED_PWM: assert property (@(posedge clk) disable iff (rst)
      (ch_att[ATT_W-1:0] == '1) |=> ##1 !ch_pwm[0]); // R2

   AST_WAVES_LOW: assert property (@(posedge clk) disable iff (rst)
      (ch_wave == '0) |=> (mix_word == '0)); // R3

   AST_MIX_IDLE: assert property (@(posedge clk) disable iff (rst)
      (mix_word == '0) |=> !mix_pwm); // R6

endmodule

bind psg_mix_pwm psg_mix_pwm_chk #(
   .NUM_CH(NUM_CH), .ATT_W(ATT_W), .AMP_W(AMP_W), .OUT_W(OUT_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ch_wave  (ch_wave),
   .ch_att   (ch_att),
   .mix_word (mix_word),
   .ch_pwm   (ch_pwm),
   .mix_pwm  (mix_pwm)
);

// File: tb/psg_mix_pwm_test.sv
`timescale 1ns/1ps
module psg_mix_pwm_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  ch_wave = '0;
   logic [15:0] ch_att = '1;
   logic [7:0]  mix_word;
   logic [3:0]  ch_pwm;
   logic        mix_pwm;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   psg_mix_pwm uut (
      .clk(clk), .rst(rst), .ch_wave(ch_wave), .ch_att(ch_att),
      .mix_word(mix_word), .ch_pwm(ch_pwm), .mix_pwm(mix_pwm)
   );

   function automatic int exp_amp(input int code);
      case (code)
         0: return 63;  1: return 50;  2: return 40;  3: return 32;
         4: return 25;  5: return 20;  6: return 16;  7: return 13;
         8: return 10;  9: return 8;   10: return 6;  11: return 5;
         12: return 4;  13: return 3;  14: return 2;  default: return 0;
      endcase
   endfunction

   function automatic int exp_sum(input logic [3:0] w, input logic [15:0] a);
      int s = 0;
      for (int i = 0; i < 4; i++) if (w[i]) s += exp_amp(int'(a[i*4 +: 4]));
      return s;
   endfunction

   function automatic int scale8(input int amp);
      return amp * 4 + amp / 16;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] w, input logic [15:0] a);
      ch_wave = w;
      ch_att  = a;
      @(negedge clk);
   endtask

   task automatic duty_check(input logic [3:0] w, input logic [15:0] a);
      int cm;
      int cc [4];
      ch_wave = w;
      ch_att  = a;
      repeat (4) @(negedge clk);
      cm = 0;
      for (int i = 0; i < 4; i++) cc[i] = 0;
      for (int k = 0; k < 256; k++) begin
         @(negedge clk);
         cm += int'(mix_pwm);
         for (int i = 0; i < 4; i++) cc[i] += int'(ch_pwm[i]);
      end
      check("R6 mix_pwm duty", cm, exp_sum(w, a));
      for (int i = 0; i < 4; i++) begin
         check("R7 ch_pwm duty", cc[i],
               w[i] ? scale8(exp_amp(int'(a[i*4 +: 4]))) : 0);
      end
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] rs;
      logic [15:0] prev_a;
      logic [3:0]  prev_w;
      int          prev_s;

      ch_wave = 4'hF;
      ch_att  = 16'h0000;
      repeat (3) @(negedge clk);
      // R8: reset state with loud inputs present
      check("R8 mix_word in reset", int'(mix_word), 0);
      check("R8 ch_pwm in reset", int'(ch_pwm), 0);
      check("R8 mix_pwm in reset", int'(mix_pwm), 0);
      rst = 1'b0;

      // R1 / R2: every code on every channel alone
      for (int ch = 0; ch < 4; ch++) begin
         for (int code = 0; code < 16; code++) begin
            logic [15:0] a;
            a = 16'hFFFF;
            a[ch*4 +: 4] = 4'(code);
            drive(4'(1 << ch), a);
            check(code == 15 ? "R2 muted channel" : "R1 amplitude table",
                  int'(mix_word), exp_amp(code));
         end
      end

      // R3: low waveforms add nothing
      drive(4'h0, 16'h0000);
      check("R3 all waves low", int'(mix_word), 0);
      drive(4'b0010, 16'h0000);
      check("R3 only ch1 high", int'(mix_word), 63);

      // R4: full scale and a pseudo-random sweep
      drive(4'hF, 16'h0000);
      check("R4 full-scale sum", int'(mix_word), 252);
      rs = 32'h1234_5678;
      for (int n = 0; n < 300; n++) begin
         rs = rs ^ (rs << 13);
         rs = rs ^ (rs >> 17);
         rs = rs ^ (rs << 5);
         drive(rs[19:16], rs[15:0]);
         check("R4 random sum", int'(mix_word), exp_sum(rs[19:16], rs[15:0]));
      end

      // R5: value holds until the next rising edge, then updates
      prev_w = 4'b0101;
      prev_a = 16'h0302;
      drive(prev_w, prev_a);
      prev_s = exp_sum(prev_w, prev_a);
      ch_wave = 4'b1010;
      ch_att  = 16'h1040;
      #1;
      check("R5 before edge", int'(mix_word), prev_s);
      @(negedge clk);
      check("R5 after edge", int'(mix_word), exp_sum(4'b1010, 16'h1040));

      // R6 / R7: duty over full counter periods
      duty_check(4'hF, 16'hFA50);
      duty_check(4'hF, 16'h0000);
      duty_check(4'b0110, 16'h3E71);
      duty_check(4'h0, 16'h0000);

      // R8: reset mid-run
      ch_wave = 4'hF;
      ch_att  = 16'h0000;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R8 mix_word after reset", int'(mix_word), 0);
      check("R8 ch_pwm after reset", int'(ch_pwm), 0);
      check("R8 mix_pwm after reset", int'(mix_pwm), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R5 after reset release", int'(mix_word), 252);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule